// File: doc/BRIEF.md
# Fuse Bit-Field Read and Burn Sequencer

This block turns one logical fuse field into a series of word-wide commands for a fuse array controller. A field is given by a base word address, the bit inside that word where it begins, its length in bits, and a flag that says whether every logical word has a mirror copy. A field may begin in the middle of a word and run across many words. The sequencer walks the field one word at a time and computes, for each word, which array bits belong to the field.

In burn mode it reads the primary copy of each word. It then programs only those field bits that the input buffer asks for and that are not yet blown. For a mirrored field it writes the same value into the mirror word as well. Every write is followed at once by a read-back of the same address. In read mode it collects the field bits, least significant first, into a 512-bit output buffer. For a mirrored field it merges the two copies with an OR, unless primary-only reading is selected. The array is powered up for the length of a sequence and returned to power-down when the sequence ends.

A host starts a sequence with a one-cycle start pulse and waits for the done pulse. The descriptor inputs are sampled at start. The write buffer must be held stable while busy is high.

Top module: `fuse_field_seq`

## Requirements
- R1: After reset, busy_o, done_o and ctl_req_o are 0, pd_o is 1 and rbuf_o is all zero.
- R2: The first word of a field holds min(length, 32 - start bit) field bits, beginning at the start bit. Every later word holds field bits from bit 0 upward. Field bit k corresponds to buffer bit k, on both wbuf_i and rbuf_o.
- R3: A field without a mirror uses consecutive addresses starting at the base. For a mirrored field, logical word w has its primary copy at base+2w and its mirror at base+2w+1.
- R4: In burn mode (burn_i=1), the value written to a word is (aligned input bits) AND NOT (primary word read) AND (field mask of that word). When this value is zero, no write is issued for that word.
- R5: For a mirrored burn, each nonzero value is written first to the primary address and then to the mirror address.
- R6: The command issued right after every write is a read of the same address.
- R7: A request is raised only if ctl_idle_i was 1 in the cycle before. While ctl_ack_i is 0, the request is held with its address, write flag and data unchanged.
- R8: In read mode (burn_i=0), a mirrored field returns the OR of the primary and mirror bits, unless primary_only_i=1; then the mirror is not read. Buffer bits at and above the field length are 0.
- R9: pd_o goes low in the cycle after a start is accepted and stays low through the done cycle. It is 1 again in the cycle after done. No request is made while pd_o is 1.
- R10: done_o is a one-cycle pulse. busy_o is high from the cycle after an accepted start up to and including the done cycle. A start seen while busy_o is high, including the done cycle, is ignored.
- R11: A length of 0 completes with done and issues no command. A length above 512 is handled as 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| burn_i | input | 1 | 1 = burn, 0 = read |
| redundant_i | input | 1 | Field has a mirror copy per word |
| primary_only_i | input | 1 | Read ignores the mirror copy |
| base_addr_i | input | ADDR_W | First word address of the field |
| start_bit_i | input | 5 | Bit position of the field in its first word |
| nbits_i | input | LEN_W | Field length in bits |
| wbuf_i | input | BUF_BITS | Bits to burn, LSB first |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pd_o | output | 1 | Array power-down request |
| rbuf_o | output | BUF_BITS | Gathered field bits, LSB first |
| ctl_req_o | output | 1 | Command request to the controller |
| ctl_we_o | output | 1 | 1 = write command, 0 = read |
| ctl_addr_o | output | ADDR_W | Command word address |
| ctl_wdata_o | output | 32 | Bits to program |
| ctl_ack_i | input | 1 | One-cycle command acknowledge |
| ctl_rdata_i | input | 32 | Read data, valid with the acknowledge |
| ctl_idle_i | input | 1 | Controller ready for a new command |

## Verification
Two events can land in the same cycle: the end of a sequence and a fresh start request. The bench holds start_i high across the done cycle and then checks that busy_o falls, that no request follows, and that pd_o returns high. A second, narrower coincidence is the controller acknowledge arriving in the same cycle as its idle line dropping. The bench's controller model lowers ctl_idle_i for a varying number of cycles after every acknowledge. The scoreboard then judges request timing against the idle line and compares every write's address and value with the expected list in order.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_P,
    S_RD_R,
    S_EVAL,
    S_WR_P,
    S_RB_P,
    S_WR_R,
    S_RB_R,
    S_DONE
  } seq_st_e;
endpackage

// File: rtl/fuse_word_map.sv
module fuse_word_map #(
  parameter int WORD_W   = 32,
  parameter int BUF_BITS = 512,
  parameter int LEN_W    = 10,
  parameter int BIT_W    = 5
) (
  input  logic [BIT_W-1:0]    first_bit,
  input  logic [LEN_W-1:0]    rem_bits,
  input  logic [LEN_W-1:0]    buf_pos,
  input  logic [BUF_BITS-1:0] wbuf,
  input  logic [WORD_W-1:0]   rd_word,
  output logic [LEN_W-1:0]    cnt,
  output logic [WORD_W-1:0]   mask,
  output logic [WORD_W-1:0]   aligned,
  output logic [BUF_BITS-1:0] gathered
);
  logic [LEN_W-1:0]    room;
  logic [LEN_W-1:0]    lim;
  logic [BUF_BITS-1:0] shifted;
  logic [WORD_W-1:0]   picked;

  // bits left in the current word from first_bit up
  assign room = LEN_W'(WORD_W) - LEN_W'(first_bit);
  assign cnt  = (rem_bits < room) ? rem_bits : room;
  assign lim  = LEN_W'(first_bit) + cnt;

  always_comb begin
    for (int b = 0; b < WORD_W; b++) begin
      mask[b] = (LEN_W'(b) >= LEN_W'(first_bit)) && (LEN_W'(b) < lim);
    end
  end

  assign shifted  = wbuf >> buf_pos;
  assign aligned  = (shifted[WORD_W-1:0] << first_bit) & mask;
  assign picked   = (rd_word & mask) >> first_bit;
  assign gathered = {{(BUF_BITS-WORD_W){1'b0}}, picked} << buf_pos;
endmodule

// File: rtl/fuse_ctl_port.sv
module fuse_ctl_port #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              cmd_done,
  output logic              ctl_req_o,
  output logic              ctl_we_o,
  output logic [ADDR_W-1:0] ctl_addr_o,
  output logic [WORD_W-1:0] ctl_wdata_o,
  input  logic              ctl_ack_i,
  input  logic              ctl_idle_i
);
  logic              req_q, req_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  logic              load;

  assign load = !req_q && cmd_valid && ctl_idle_i;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (load) begin
      req_d  = 1'b1;
      we_d   = cmd_we;
      addr_d = cmd_addr;
      wdat_d = cmd_wdata;
    end else if (req_q && ctl_ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      req_q <= req_d;
      if (load) begin
        we_q   <= we_d;
        addr_q <= addr_d;
        wdat_q <= wdat_d;
      end
    end
  end

  assign cmd_done    = req_q && ctl_ack_i;
  assign ctl_req_o   = req_q;
  assign ctl_we_o    = we_q;
  assign ctl_addr_o  = addr_q;
  assign ctl_wdata_o = wdat_q;

  p_req_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_req_o) |-> $past(ctl_idle_i));
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_o && !ctl_ack_i) |=> (ctl_req_o && $stable(ctl_addr_o) &&
                                   $stable(ctl_we_o) && $stable(ctl_wdata_o)));
endmodule

// File: rtl/fuse_field_seq.sv
module fuse_field_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BUF_BITS = 512,
  parameter int WORD_W   = 32,
  parameter int BIT_W    = $clog2(WORD_W),
  parameter int LEN_W    = $clog2(BUF_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                burn_i,
  input  logic                redundant_i,
  input  logic                primary_only_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [BIT_W-1:0]    start_bit_i,
  input  logic [LEN_W-1:0]    nbits_i,
  input  logic [BUF_BITS-1:0] wbuf_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                pd_o,
  output logic [BUF_BITS-1:0] rbuf_o,
  output logic                ctl_req_o,
  output logic                ctl_we_o,
  output logic [ADDR_W-1:0]   ctl_addr_o,
  output logic [WORD_W-1:0]   ctl_wdata_o,
  input  logic                ctl_ack_i,
  input  logic [WORD_W-1:0]   ctl_rdata_i,
  input  logic                ctl_idle_i
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BITS);

  seq_st_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BIT_W-1:0]    first_q, first_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  logic [LEN_W-1:0]    pos_q, pos_d;
  logic                red_q, burn_q, ponly_q;
  logic                mode_en;
  logic [WORD_W-1:0]   curp_q, curp_d, curr_q, curr_d;
  logic [BUF_BITS-1:0] rbuf_q, rbuf_d;
  logic                rbuf_en;
  logic                pd_q, pd_d;
  logic                step;

  logic [LEN_W-1:0]    nb_eff;
  logic [LEN_W-1:0]    cnt;
  logic [WORD_W-1:0]   mask, aligned, merged, burn_val;
  logic [BUF_BITS-1:0] gathered;

  logic                cmd_valid, cmd_we, cmd_done;
  logic [ADDR_W-1:0]   cmd_addr;

  assign nb_eff = (nbits_i > MAX_LEN) ? MAX_LEN : nbits_i;
  assign merged = curp_q | ((red_q && !ponly_q) ? curr_q : '0);

  fuse_word_map #(
    .WORD_W(WORD_W), .BUF_BITS(BUF_BITS), .LEN_W(LEN_W), .BIT_W(BIT_W)
  ) u_map (
    .first_bit(first_q),
    .rem_bits (rem_q),
    .buf_pos  (pos_q),
    .wbuf     (wbuf_i),
    .rd_word  (merged),
    .cnt      (cnt),
    .mask     (mask),
    .aligned  (aligned),
    .gathered (gathered)
  );

  assign burn_val = aligned & ~curp_q & mask;

  // command selection per state
  always_comb begin
    cmd_valid = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = addr_q;
    unique case (st_q)
      S_RD_P, S_RB_P: cmd_valid = 1'b1;
      S_WR_P: begin cmd_valid = 1'b1; cmd_we = 1'b1; end
      S_RD_R, S_RB_R: begin cmd_valid = 1'b1; cmd_addr = addr_q + ADDR_W'(1); end
      S_WR_R: begin
        cmd_valid = 1'b1;
        cmd_we    = 1'b1;
        cmd_addr  = addr_q + ADDR_W'(1);
      end
      default: cmd_valid = 1'b0;
    endcase
  end

  fuse_ctl_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_we     (cmd_we),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (burn_val),
    .cmd_done   (cmd_done),
    .ctl_req_o  (ctl_req_o),
    .ctl_we_o   (ctl_we_o),
    .ctl_addr_o (ctl_addr_o),
    .ctl_wdata_o(ctl_wdata_o),
    .ctl_ack_i  (ctl_ack_i),
    .ctl_idle_i (ctl_idle_i)
  );

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    first_d = first_q;
    rem_d   = rem_q;
    pos_d   = pos_q;
    curp_d  = curp_q;
    curr_d  = curr_q;
    rbuf_d  = rbuf_q;
    pd_d    = pd_q;
    mode_en = 1'b0;
    rbuf_en = 1'b0;
    step    = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = (nb_eff == '0) ? S_DONE : S_RD_P;
        addr_d  = base_addr_i;
        first_d = start_bit_i;
        rem_d   = nb_eff;
        pos_d   = '0;
        rbuf_d  = '0;
        rbuf_en = 1'b1;
        mode_en = 1'b1;
        pd_d    = 1'b0;
      end
      S_RD_P: if (cmd_done) begin
        curp_d = ctl_rdata_i;
        st_d   = (red_q && !burn_q && !ponly_q) ? S_RD_R : S_EVAL;
      end
      S_RD_R: if (cmd_done) begin
        curr_d = ctl_rdata_i;
        st_d   = S_EVAL;
      end
      S_EVAL: begin
        if (burn_q && (burn_val != '0)) begin
          st_d = S_WR_P;
        end else begin
          step = 1'b1;
          if (!burn_q) begin
            rbuf_d  = rbuf_q | gathered;
            rbuf_en = 1'b1;
          end
        end
      end
      S_WR_P: if (cmd_done) st_d = S_RB_P;
      S_RB_P: if (cmd_done) begin
        if (red_q) st_d = S_WR_R;
        else       step = 1'b1;
      end
      S_WR_R: if (cmd_done) st_d = S_RB_R;
      S_RB_R: if (cmd_done) step = 1'b1;
      S_DONE: begin
        st_d = S_IDLE;
        pd_d = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    if (step) begin
      rem_d   = rem_q - cnt;
      pos_d   = pos_q + cnt;
      first_d = '0;
      addr_d  = addr_q + (red_q ? ADDR_W'(2) : ADDR_W'(1));
      st_d    = (rem_q == cnt) ? S_DONE : S_RD_P;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      first_q <= '0;
      rem_q   <= '0;
      pos_q   <= '0;
      red_q   <= 1'b0;
      burn_q  <= 1'b0;
      ponly_q <= 1'b0;
      curp_q  <= '0;
      curr_q  <= '0;
      rbuf_q  <= '0;
      pd_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      first_q <= first_d;
      rem_q   <= rem_d;
      pos_q   <= pos_d;
      curp_q  <= curp_d;
      curr_q  <= curr_d;
      pd_q    <= pd_d;
      if (mode_en) begin
        red_q   <= redundant_i;
        burn_q  <= burn_i;
        ponly_q <= primary_only_i;
      end
      if (rbuf_en) rbuf_q <= rbuf_d;
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
  assign pd_o   = pd_q;
  assign rbuf_o = rbuf_q;

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  p_pd_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_req_o |-> !pd_o);
  p_no_zero_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_o && ctl_we_o) |-> (ctl_wdata_o != '0));
  p_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req_o && ctl_we_o && ctl_ack_i) |=> (st_q == S_RB_P || st_q == S_RB_R));
endmodule

// File: tb/fuse_field_seq_tb.sv
module fuse_field_seq_tb;
  logic         clk;
  logic         rst_n;
  logic         start_i, burn_i, redundant_i, primary_only_i;
  logic [7:0]   base_addr_i;
  logic [4:0]   start_bit_i;
  logic [9:0]   nbits_i;
  logic [511:0] wbuf_i;
  logic         busy_o, done_o, pd_o;
  logic [511:0] rbuf_o;
  logic         ctl_req_o, ctl_we_o;
  logic [7:0]   ctl_addr_o;
  logic [31:0]  ctl_wdata_o;
  logic         ctl_ack_i;
  logic [31:0]  ctl_rdata_i;
  logic         ctl_idle_i;

  fuse_field_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .burn_i(burn_i),
    .redundant_i(redundant_i), .primary_only_i(primary_only_i),
    .base_addr_i(base_addr_i), .start_bit_i(start_bit_i), .nbits_i(nbits_i),
    .wbuf_i(wbuf_i), .busy_o(busy_o), .done_o(done_o), .pd_o(pd_o),
    .rbuf_o(rbuf_o), .ctl_req_o(ctl_req_o), .ctl_we_o(ctl_we_o),
    .ctl_addr_o(ctl_addr_o), .ctl_wdata_o(ctl_wdata_o), .ctl_ack_i(ctl_ack_i),
    .ctl_rdata_i(ctl_rdata_i), .ctl_idle_i(ctl_idle_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // controller and fuse array model
  logic [31:0] mem [256];
  int lat, gap, pat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++)
        mem[i] <= (i < 128) ? 32'h0 : (32'(i) * 32'h9E3779B1);
      ctl_ack_i <= 1'b0; ctl_idle_i <= 1'b1; ctl_rdata_i <= '0;
      lat <= 0; gap <= 0; pat <= 0;
    end else if (ctl_ack_i) begin
      ctl_ack_i  <= 1'b0;
      ctl_idle_i <= 1'b0;
      gap        <= pat % 3;
      pat        <= pat + 1;
    end else begin
      if (!ctl_idle_i) begin
        if (gap == 0) ctl_idle_i <= 1'b1;
        else gap <= gap - 1;
      end
      if (ctl_req_o && ctl_idle_i) begin
        if (lat == 0) begin
          ctl_ack_i   <= 1'b1;
          ctl_rdata_i <= mem[ctl_addr_o];
          if (ctl_we_o) mem[ctl_addr_o] <= mem[ctl_addr_o] | ctl_wdata_o;
          lat <= pat % 4;
        end else lat <= lat - 1;
      end
    end
  end

  // scoreboard queues
  logic [7:0]  exp_addr [$];
  logic [31:0] exp_data [$];
  int n_cmp, n_fail, m_cmp, m_fail, n_cmds;
  bit rb_pend, prev_req, prev_idle;
  logic [7:0] rb_addr;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ctl_req_o && !prev_req) begin
        m_cmp++;
        if (!prev_idle) begin
          m_fail++;
          $display("FAIL R7: request raised after non-idle cycle, idle=%0d exp=1", prev_idle);
        end
      end
      if (ctl_req_o) begin
        m_cmp++;
        if (pd_o) begin m_fail++; $display("FAIL R9: request with pd_o=%0d exp=0", pd_o); end
      end
      if (ctl_req_o && ctl_ack_i) begin
        n_cmds++;
        if (rb_pend) begin
          m_cmp++;
          if (ctl_we_o || ctl_addr_o != rb_addr) begin
            m_fail++;
            $display("FAIL R6: after write got we=%0d addr=%0h exp we=0 addr=%0h",
                     ctl_we_o, ctl_addr_o, rb_addr);
          end
          rb_pend = 1'b0;
        end
        if (ctl_we_o) begin
          m_cmp++;
          if (exp_addr.size() == 0) begin
            m_fail++;
            $display("FAIL R4: unexpected write addr=%0h data=%h exp none", ctl_addr_o, ctl_wdata_o);
          end else begin
            logic [7:0]  ea;
            logic [31:0] ed;
            ea = exp_addr.pop_front();
            ed = exp_data.pop_front();
            if (ea != ctl_addr_o || ed != ctl_wdata_o) begin
              m_fail++;
              $display("FAIL R3/R4/R5: write addr=%0h data=%h exp addr=%0h data=%h",
                       ctl_addr_o, ctl_wdata_o, ea, ed);
            end
          end
          rb_pend = 1'b1;
          rb_addr = ctl_addr_o;
        end
      end
    end
    prev_req  = ctl_req_o;
    prev_idle = ctl_idle_i;
  end

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit burn, input bit red, input bit ponly, input logic [7:0] base,
                        input logic [4:0] sb, input int n, input logic [511:0] data,
                        input bit hold_start, input string tag);
    int ne, step, guard, cmds0;
    logic [31:0]  wv [18];
    logic [31:0]  wm [18];
    logic [511:0] exp_rd;
    ne = (n > 512) ? 512 : n;
    step = red ? 2 : 1;
    exp_rd = '0;
    for (int w = 0; w < 18; w++) begin wv[w] = '0; wm[w] = '0; end
    for (int i = 0; i < ne; i++) begin
      int p, w, b;
      logic [7:0] a;
      p = int'(sb) + i; w = p / 32; b = p % 32;
      a = base + 8'(w * step);
      wm[w][b] = 1'b1;
      wv[w][b] = data[i];
      exp_rd[i] = mem[a][b] | ((red && !ponly) ? mem[a + 8'd1][b] : 1'b0);
    end
    if (burn) begin
      for (int w = 0; w < 18; w++) begin
        logic [7:0]  a;
        logic [31:0] v;
        a = base + 8'(w * step);
        v = wv[w] & ~mem[a] & wm[w];
        if (v != 0) begin
          exp_addr.push_back(a); exp_data.push_back(v);
          if (red) begin exp_addr.push_back(a + 8'd1); exp_data.push_back(v); end
        end
      end
    end
    cmds0 = n_cmds;
    @(negedge clk);
    burn_i = burn; redundant_i = red; primary_only_i = ponly;
    base_addr_i = base; start_bit_i = sb; nbits_i = 10'(n); wbuf_i = data;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R10 busy after start ", tag}, 512'(busy_o), 512'd1);
    chk(pd_o == 1'b0, {"R9 pd low when busy ", tag}, 512'(pd_o), 512'd0);
    guard = 0;
    while (!done_o && guard < 20000) begin @(negedge clk); guard++; end
    chk(done_o == 1'b1, {"R10 done reached ", tag}, 512'(done_o), 512'd1);
    chk(busy_o == 1'b1, {"R10 busy in done cycle ", tag}, 512'(busy_o), 512'd1);
    if (!burn) chk(rbuf_o == exp_rd, {"R2/R8 read data ", tag}, rbuf_o, exp_rd);
    if (hold_start) start_i = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, {"R10 done single, start ignored ", tag},
        512'({done_o, busy_o}), 512'd0);
    chk(pd_o == 1'b1, {"R9 pd back high ", tag}, 512'(pd_o), 512'd1);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0 && ctl_req_o == 1'b0, {"R10 quiet after done ", tag},
        512'({busy_o, ctl_req_o}), 512'd0);
    chk(exp_addr.size() == 0, {"R4/R5 all expected writes seen ", tag},
        512'(exp_addr.size()), 512'd0);
    exp_addr.delete(); exp_data.delete();
    if (ne == 0)
      chk(n_cmds == cmds0, {"R11 zero length issues no command ", tag},
          512'(n_cmds - cmds0), 512'd0);
  endtask

  bit wd_hit;
  initial begin
    wd_hit = 1'b0;
    repeat (150000) @(posedge clk);
    wd_hit = 1'b1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp + 1, n_fail + m_fail + 1);
    $finish;
  end

  initial begin
    n_cmp = 0; n_fail = 0; m_cmp = 0; m_fail = 0; n_cmds = 0;
    rb_pend = 1'b0; prev_req = 1'b0; prev_idle = 1'b1; rb_addr = '0;
    start_i = 0; burn_i = 0; redundant_i = 0; primary_only_i = 0;
    base_addr_i = '0; start_bit_i = '0; nbits_i = '0; wbuf_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0 && ctl_req_o == 0, "R1 reset outputs low",
        512'({busy_o, done_o, ctl_req_o}), 512'd0);
    chk(pd_o == 1'b1, "R1 reset power-down", 512'(pd_o), 512'd1);
    chk(rbuf_o == '0, "R1 reset buffer", rbuf_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(0, 0, 0, 8'd130, 5'd5,  40, '0, 0, "R2 read plain mid-word");
    run_op(0, 1, 0, 8'd140, 5'd7,  70, '0, 0, "R3 R8 read mirrored OR");
    run_op(0, 1, 1, 8'd140, 5'd7,  70, '0, 0, "R8 read primary only");
    run_op(1, 0, 0, 8'd10,  5'd30, 64, 512'h1234_5678_9ABC_DEF0, 0, "R2 R3 burn plain across words");
    run_op(0, 0, 0, 8'd10,  5'd30, 64, '0, 0, "R2 read back plain burn");
    run_op(1, 1, 0, 8'd20,  5'd2,  8,  512'h5A, 0, "R5 burn mirrored partial");
    run_op(1, 1, 0, 8'd20,  5'd2,  32, 512'hFFFF_00FF, 0, "R4 R5 burn skips blown bits");
    run_op(0, 1, 0, 8'd20,  5'd2,  32, '0, 0, "R8 read back mirrored");
    run_op(1, 1, 0, 8'd20,  5'd2,  32, 512'hFFFF_00FF, 0, "R4 burn all blown gives no write");
    run_op(1, 0, 0, 8'd40,  5'd0,  512, {16{32'hC0DE_5A3B}}, 0, "R2 burn full buffer");
    run_op(0, 0, 0, 8'd40,  5'd0,  600, '0, 0, "R11 length clamp to 512");
    run_op(0, 1, 0, 8'd60,  5'd21, 100, '0, 0, "R3 mirrored read start 21");
    run_op(0, 0, 0, 8'd150, 5'd3,  0,  '0, 0, "R11 zero length");
    run_op(0, 0, 0, 8'd150, 5'd31, 2,  '0, 1, "R10 start held across done");

    if (!wd_hit) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + m_cmp, n_fail + m_fail);
      $finish;
    end
  end
endmodule